// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns an operand reference into a memory location for a 16-bit segmented register model. A request names an addressing-mode code, a displacement size and a displacement, and brings in the current base registers (BX, BP), index registers (SI, DI) and segment registers (ES, CS, SS, DS). The block adds up the selected terms into a 16-bit effective offset and picks the segment the reference belongs to. It then forms a 20-bit physical address by shifting the segment value left by four bits and adding the offset.

The results are registered. They appear one clock after the request, together with a valid flag. Between requests the outputs keep their last values. An optional override input replaces the default segment choice. An upstream decoder supplies the mode and displacement fields. The 20-bit address goes to the bus logic.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is high, and on the first clock after it, `res_valid` is 0 and `res_offset`, `res_seg_val`, `res_seg_id` and `res_phys` are all 0.
- R2: `res_valid` is 1 exactly in the cycle after a clock edge that samples `req_valid` high, and 0 otherwise. When `req_valid` is low, the data outputs keep their values.
- R3: The mode code `mode_rm` selects the register terms of the offset as follows: 0 = BX+SI, 1 = BX+DI, 2 = BP+SI, 3 = BP+DI, 4 = SI, 5 = DI, 6 = BP, 7 = BX. BX never combines with BP, and SI never combines with DI.
- R4: The size code `disp_size` works as follows: 0 adds no displacement, and 1 adds `disp[7:0]` sign extended to 16 bits. With code 1, `disp[15:8]` has no effect.
- R5: Mode 6 with size code 0 is a direct reference. The offset equals `disp` (all 16 bits), no register is added, and the default segment is DS.
- R6: With no override, the segment is SS for modes 2 and 3, and for mode 6 with a size code other than 0. The segment is DS in every other case.
- R7: When `seg_ovr_en` is 1, `seg_ovr_sel` picks the segment with the codes 0 = ES, 1 = CS, 2 = SS, 3 = DS, and the default is ignored. `res_seg_id` reports the chosen segment with the same codes, and `res_seg_val` reports its value.
- R8: The offset sum wraps modulo 2^16.
- R9: `res_phys` equals (`res_seg_val` * 16 + `res_offset`) modulo 2^20.
- R10: Size codes 2 and 3 both add the full 16-bit `disp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; fields below are sampled with it |
| mode_rm | input | 3 | Addressing-mode code (register terms) |
| disp_size | input | 2 | Displacement size code |
| disp | input | 16 | Displacement value |
| reg_bx | input | 16 | Base register BX |
| reg_bp | input | 16 | Base register BP |
| reg_si | input | 16 | Index register SI |
| reg_di | input | 16 | Index register DI |
| seg_es | input | 16 | Segment register ES |
| seg_cs | input | 16 | Segment register CS |
| seg_ss | input | 16 | Segment register SS |
| seg_ds | input | 16 | Segment register DS |
| seg_ovr_en | input | 1 | Segment override enable |
| seg_ovr_sel | input | 2 | Override segment code |
| res_valid | output | 1 | Result valid, one clock after request |
| res_offset | output | 16 | Effective offset |
| res_seg_id | output | 2 | Code of the chosen segment |
| res_seg_val | output | 16 | Value of the chosen segment |
| res_phys | output | 20 | Physical address |

## Verification
The assertions compare the outputs with input fields captured one cycle earlier. They therefore assume the input fields are valid in the cycle where `req_valid` is sampled high, and they do not care about the inputs at any other time. The stimulus changes every field only on the falling clock edge. Between requests it drops `req_valid` for at least one cycle while it keeps scrambling the data inputs, so the hold behaviour is actually tested. The random requests draw every mode code, every size code and both override states. The directed cases force carries out of bit 15 and out of bit 19, and a displacement byte with its top bit set under a non-zero upper byte.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_id_e;

  typedef enum logic [1:0] {
    DK_NONE = 2'd0,
    DK_BYTE = 2'd1,
    DK_WORD = 2'd2
  } disp_kind_e;

  typedef struct packed {
    logic       use_bx;
    logic       use_bp;
    logic       use_si;
    logic       use_di;
    disp_kind_e dkind;
  } ea_terms_t;

endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
  import seg_addr_pkg::*;
(
  input  logic [2:0] mode_rm,
  input  logic [1:0] disp_size,
  output ea_terms_t  terms
);

  disp_kind_e dk;

  always_comb begin
    unique case (disp_size)
      2'd0:    dk = DK_NONE;
      2'd1:    dk = DK_BYTE;
      default: dk = DK_WORD;
    endcase
  end

  always_comb begin
    terms = '{use_bx: 1'b0, use_bp: 1'b0, use_si: 1'b0, use_di: 1'b0, dkind: dk};
    unique case (mode_rm)
      3'd0: begin terms.use_bx = 1'b1; terms.use_si = 1'b1; end
      3'd1: begin terms.use_bx = 1'b1; terms.use_di = 1'b1; end
      3'd2: begin terms.use_bp = 1'b1; terms.use_si = 1'b1; end
      3'd3: begin terms.use_bp = 1'b1; terms.use_di = 1'b1; end
      3'd4: terms.use_si = 1'b1;
      3'd5: terms.use_di = 1'b1;
      3'd6: begin
        if (dk == DK_NONE) terms.dkind  = DK_WORD;
        else               terms.use_bp = 1'b1;
      end
      default: terms.use_bx = 1'b1;
    endcase
  end

endmodule

// File: rtl/ea_offset_sum.sv
module ea_offset_sum
  import seg_addr_pkg::*;
#(
  parameter int OFS_W   = 16,
  parameter int DISP8_W = 8
) (
  input  ea_terms_t          terms,
  input  logic [OFS_W-1:0]   reg_bx,
  input  logic [OFS_W-1:0]   reg_bp,
  input  logic [OFS_W-1:0]   reg_si,
  input  logic [OFS_W-1:0]   reg_di,
  input  logic [OFS_W-1:0]   disp,
  output logic [OFS_W-1:0]   offset
);

  localparam int EXT_W = OFS_W - DISP8_W;

  logic [OFS_W-1:0] base_term;
  logic [OFS_W-1:0] index_term;
  logic [OFS_W-1:0] disp_term;

  always_comb begin
    base_term = '0;
    if (terms.use_bx)      base_term = reg_bx;
    else if (terms.use_bp) base_term = reg_bp;
  end

  always_comb begin
    index_term = '0;
    if (terms.use_si)      index_term = reg_si;
    else if (terms.use_di) index_term = reg_di;
  end

  always_comb begin
    unique case (terms.dkind)
      DK_BYTE: disp_term = {{EXT_W{disp[DISP8_W-1]}}, disp[DISP8_W-1:0]};
      DK_WORD: disp_term = disp;
      default: disp_term = '0;
    endcase
  end

  // Sum truncates naturally to OFS_W bits.
  assign offset = base_term + index_term + disp_term;

endmodule

// File: rtl/ea_segment_select.sv
module ea_segment_select
  import seg_addr_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int N_SEG  = 4
) (
  input  logic                  bp_based,
  input  logic                  ovr_en,
  input  logic [1:0]            ovr_sel,
  input  logic [N_SEG*OFS_W-1:0] seg_bank,
  output seg_id_e               seg_id,
  output logic [OFS_W-1:0]      seg_val
);

  logic [OFS_W-1:0] seg_arr [N_SEG];

  for (genvar g = 0; g < N_SEG; g++) begin : g_unpack
    assign seg_arr[g] = seg_bank[g*OFS_W +: OFS_W];
  end

  always_comb begin
    if (ovr_en)        seg_id = seg_id_e'(ovr_sel);
    else if (bp_based) seg_id = SEG_SS;
    else               seg_id = SEG_DS;
  end

  assign seg_val = seg_arr[seg_id];

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int DISP8_W   = 8,
  parameter int SEG_SHIFT = 4,
  localparam int PA_W     = OFS_W + SEG_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [2:0]       mode_rm,
  input  logic [1:0]       disp_size,
  input  logic [OFS_W-1:0] disp,
  input  logic [OFS_W-1:0] reg_bx,
  input  logic [OFS_W-1:0] reg_bp,
  input  logic [OFS_W-1:0] reg_si,
  input  logic [OFS_W-1:0] reg_di,
  input  logic [OFS_W-1:0] seg_es,
  input  logic [OFS_W-1:0] seg_cs,
  input  logic [OFS_W-1:0] seg_ss,
  input  logic [OFS_W-1:0] seg_ds,
  input  logic             seg_ovr_en,
  input  logic [1:0]       seg_ovr_sel,
  output logic             res_valid,
  output logic [OFS_W-1:0] res_offset,
  output logic [1:0]       res_seg_id,
  output logic [OFS_W-1:0] res_seg_val,
  output logic [PA_W-1:0]  res_phys
);

  localparam int N_SEG = 4;

  ea_terms_t          terms;
  logic [OFS_W-1:0]   offset_c;
  seg_id_e            seg_id_c;
  logic [OFS_W-1:0]   seg_val_c;
  logic [PA_W-1:0]    phys_c;
  logic [N_SEG*OFS_W-1:0] seg_bank;

  // Bank order follows the segment code: ES, CS, SS, DS.
  assign seg_bank = {seg_ds, seg_ss, seg_cs, seg_es};

  ea_mode_decode u_decode (
    .mode_rm   (mode_rm),
    .disp_size (disp_size),
    .terms     (terms)
  );

  ea_offset_sum #(
    .OFS_W   (OFS_W),
    .DISP8_W (DISP8_W)
  ) u_sum (
    .terms  (terms),
    .reg_bx (reg_bx),
    .reg_bp (reg_bp),
    .reg_si (reg_si),
    .reg_di (reg_di),
    .disp   (disp),
    .offset (offset_c)
  );

  ea_segment_select #(
    .OFS_W (OFS_W),
    .N_SEG (N_SEG)
  ) u_seg (
    .bp_based (terms.use_bp),
    .ovr_en   (seg_ovr_en),
    .ovr_sel  (seg_ovr_sel),
    .seg_bank (seg_bank),
    .seg_id   (seg_id_c),
    .seg_val  (seg_val_c)
  );

  assign phys_c = {seg_val_c, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, offset_c};

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_offset  <= '0;
      res_seg_id  <= '0;
      res_seg_val <= '0;
      res_phys    <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_offset  <= offset_c;
        res_seg_id  <= seg_id_c;
        res_seg_val <= seg_val_c;
        res_phys    <= phys_c;
      end
    end
  end

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PA_W     = OFS_W + SEG_SHIFT
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [2:0]       mode_rm,
  input logic [1:0]       disp_size,
  input logic [OFS_W-1:0] disp,
  input logic [OFS_W-1:0] reg_bx,
  input logic             seg_ovr_en,
  input logic [1:0]       seg_ovr_sel,
  input logic             res_valid,
  input logic [OFS_W-1:0] res_offset,
  input logic [1:0]       res_seg_id,
  input logic [OFS_W-1:0] res_seg_val,
  input logic [PA_W-1:0]  res_phys
);

  // R2: valid follows the request by one clock
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  a_r2_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(res_offset) && $stable(res_phys) && $stable(res_seg_id)));

  // R3: plain BX mode without displacement gives BX
  a_r3_bx_only: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode_rm == 3'd7 && disp_size == 2'd0) |=> res_offset == $past(reg_bx));

  // R5: direct reference
  a_r5_direct: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode_rm == 3'd6 && disp_size == 2'd0) |=>
      (res_offset == $past(disp)));

  // R6: default segment choice
  a_r6_ss_default: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !seg_ovr_en && (mode_rm == 3'd2 || mode_rm == 3'd3 ||
      (mode_rm == 3'd6 && disp_size != 2'd0))) |=> res_seg_id == 2'd2);
  a_r6_ds_default: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !seg_ovr_en && (mode_rm == 3'd0 || mode_rm == 3'd1 ||
      mode_rm == 3'd4 || mode_rm == 3'd5 || mode_rm == 3'd7 ||
      (mode_rm == 3'd6 && disp_size == 2'd0))) |=> res_seg_id == 2'd3);

  // R7: override wins
  a_r7_override: assert property (@(posedge clk) disable iff (rst)
    (req_valid && seg_ovr_en) |=> res_seg_id == $past(seg_ovr_sel));

  // R9: address composition of the reported segment and offset
  a_r9_phys: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_phys == PA_W'({res_seg_val, {SEG_SHIFT{1'b0}}} +
                                    {{SEG_SHIFT{1'b0}}, res_offset}));

endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .OFS_W     (OFS_W),
  .SEG_SHIFT (SEG_SHIFT)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .mode_rm     (mode_rm),
  .disp_size   (disp_size),
  .disp        (disp),
  .reg_bx      (reg_bx),
  .seg_ovr_en  (seg_ovr_en),
  .seg_ovr_sel (seg_ovr_sel),
  .res_valid   (res_valid),
  .res_offset  (res_offset),
  .res_seg_id  (res_seg_id),
  .res_seg_val (res_seg_val),
  .res_phys    (res_phys)
);

// File: tb/seg_addr_gen_tb.sv
`timescale 1ns/1ps
module seg_addr_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [2:0]  mode_rm;
  logic [1:0]  disp_size;
  logic [15:0] disp, reg_bx, reg_bp, reg_si, reg_di;
  logic [15:0] seg_es, seg_cs, seg_ss, seg_ds;
  logic        seg_ovr_en;
  logic [1:0]  seg_ovr_sel;
  logic        res_valid;
  logic [15:0] res_offset;
  logic [1:0]  res_seg_id;
  logic [15:0] res_seg_val;
  logic [19:0] res_phys;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  seg_addr_gen dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .mode_rm(mode_rm),
    .disp_size(disp_size), .disp(disp), .reg_bx(reg_bx), .reg_bp(reg_bp),
    .reg_si(reg_si), .reg_di(reg_di), .seg_es(seg_es), .seg_cs(seg_cs),
    .seg_ss(seg_ss), .seg_ds(seg_ds), .seg_ovr_en(seg_ovr_en),
    .seg_ovr_sel(seg_ovr_sel), .res_valid(res_valid), .res_offset(res_offset),
    .res_seg_id(res_seg_id), .res_seg_val(res_seg_val), .res_phys(res_phys)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] m_offset(input logic [2:0] m, input logic [1:0] ds,
                                           input logic [15:0] d);
    logic [15:0] sum, dv;
    case (ds)
      2'd0: dv = 16'h0;
      2'd1: dv = d[7] ? {8'hFF, d[7:0]} : {8'h00, d[7:0]};
      default: dv = d;
    endcase
    case (m)
      3'd0: sum = reg_bx + reg_si;
      3'd1: sum = reg_bx + reg_di;
      3'd2: sum = reg_bp + reg_si;
      3'd3: sum = reg_bp + reg_di;
      3'd4: sum = reg_si;
      3'd5: sum = reg_di;
      3'd6: sum = (ds == 2'd0) ? 16'h0 : reg_bp;
      default: sum = reg_bx;
    endcase
    if (m == 3'd6 && ds == 2'd0) return d;
    return sum + dv;
  endfunction

  function automatic logic [1:0] m_seg_id(input logic [2:0] m, input logic [1:0] ds,
                                          input logic oe, input logic [1:0] os);
    if (oe) return os;
    if (m == 3'd2 || m == 3'd3 || (m == 3'd6 && ds != 2'd0)) return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [15:0] m_seg_val(input logic [1:0] id);
    case (id)
      2'd0: return seg_es;
      2'd1: return seg_cs;
      2'd2: return seg_ss;
      default: return seg_ds;
    endcase
  endfunction

  // Issue one request, check the registered result, then check one idle cycle.
  task automatic run_req(input string tag, input logic [2:0] m, input logic [1:0] ds,
                         input logic [15:0] d, input logic oe, input logic [1:0] os);
    logic [15:0] e_ofs, e_seg;
    logic [1:0]  e_id;
    logic [19:0] e_pa;
    @(negedge clk);
    mode_rm = m; disp_size = ds; disp = d; seg_ovr_en = oe; seg_ovr_sel = os;
    req_valid = 1'b1;
    e_ofs = m_offset(m, ds, d);
    e_id  = m_seg_id(m, ds, oe, os);
    e_seg = m_seg_val(e_id);
    e_pa  = {e_seg, 4'h0} + {4'h0, e_ofs};
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R2"}, "valid", 32'(res_valid), 32'd1);
    check({tag, " R3"}, "offset", 32'(res_offset), 32'(e_ofs));
    check({tag, " R7"}, "seg_id", 32'(res_seg_id), 32'(e_id));
    check({tag, " R7"}, "seg_val", 32'(res_seg_val), 32'(e_seg));
    check({tag, " R9"}, "phys", 32'(res_phys), 32'(e_pa));
    // scramble inputs while idle; outputs must hold (R2)
    disp = 16'(~d); reg_bx = reg_bx ^ 16'h5A5A; mode_rm = ~m; seg_ovr_en = ~oe;
    @(negedge clk);
    check({tag, " R2"}, "idle valid", 32'(res_valid), 32'd0);
    check({tag, " R2"}, "hold offset", 32'(res_offset), 32'(e_ofs));
    check({tag, " R2"}, "hold phys", 32'(res_phys), 32'(e_pa));
    reg_bx = reg_bx ^ 16'h5A5A;
  endtask

  task automatic set_regs(input logic [15:0] bx, bp, si, di, es, cs, ss, ds);
    reg_bx = bx; reg_bp = bp; reg_si = si; reg_di = di;
    seg_es = es; seg_cs = cs; seg_ss = ss; seg_ds = ds;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; req_valid = 1'b0; mode_rm = '0; disp_size = '0; disp = '0;
    seg_ovr_en = 1'b0; seg_ovr_sel = '0;
    set_regs(16'h1111, 16'h2222, 16'h3333, 16'h4444,
             16'hE000, 16'hC000, 16'h5000, 16'hD000);
    req_valid = 1'b1;   // must be ignored under reset
    repeat (3) @(negedge clk);
    check("R1", "valid in reset", 32'(res_valid), 32'd0);
    check("R1", "offset in reset", 32'(res_offset), 32'd0);
    check("R1", "phys in reset", 32'(res_phys), 32'd0);
    req_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R1", "valid after reset", 32'(res_valid), 32'd0);
    check("R1", "seg after reset", 32'(res_seg_val), 32'd0);

    // R3 every mode, no displacement
    for (int m = 0; m < 8; m++) run_req("R3", 3'(m), 2'd0, 16'h0000, 1'b0, 2'd0);
    // R5 direct reference: offset = disp, DS
    run_req("R5", 3'd6, 2'd0, 16'hBEEF, 1'b0, 2'd0);
    check("R5", "direct seg DS", 32'(res_seg_id), 32'd3);
    // R6 BP with byte displacement -> SS
    run_req("R6", 3'd6, 2'd1, 16'h0004, 1'b0, 2'd0);
    check("R6", "bp seg SS", 32'(res_seg_id), 32'd2);
    // R4 negative byte, garbage upper byte: BX + 0xFF80
    set_regs(16'h1000, 16'h2222, 16'h3333, 16'h4444,
             16'hE000, 16'hC000, 16'h5000, 16'hD000);
    run_req("R4", 3'd7, 2'd1, 16'hAB80, 1'b0, 2'd0);
    check("R4", "sign ext offset", 32'(res_offset), 32'h0F80);
    // R10 size code 3 adds full word
    run_req("R10", 3'd7, 2'd3, 16'h1234, 1'b0, 2'd0);
    check("R10", "word disp code 3", 32'(res_offset), 32'h2234);
    // R8 offset wrap
    set_regs(16'hFFFF, 16'h2222, 16'h0002, 16'h4444,
             16'hE000, 16'hC000, 16'h5000, 16'hFFFF);
    run_req("R8", 3'd0, 2'd0, 16'h0000, 1'b0, 2'd0);
    check("R8", "offset wrap", 32'(res_offset), 32'h0001);
    // R9 physical wrap: FFFF0 + FFFF -> 0FFEF
    run_req("R9", 3'd6, 2'd0, 16'hFFFF, 1'b0, 2'd0);
    check("R9", "phys wrap", 32'(res_phys), 32'h0FFEF);
    // R7 each override code on a BP mode
    for (int s = 0; s < 4; s++) run_req("R7", 3'd2, 2'd2, 16'h0010, 1'b1, 2'(s));

    // Constrained random
    for (int i = 0; i < 400; i++) begin
      set_regs(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
               16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
      run_req("RND R3 R4 R6", 3'($urandom), 2'($urandom), 16'($urandom),
              1'($urandom), 2'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule